// File: doc/BRIEF.md
# Prefetching Instruction Cache Controller

This block sits between the instruction fetch port of a 16-bit processor and a slow non-volatile code memory. Instruction words are held in a small two-way set-associative buffer whose lines carry four consecutive words (64 bits). A fetch that finds its word in the buffer is answered in the same cycle. A fetch that misses stalls the processor while the whole aligned line is read from memory, and then the requested word is returned.

The code memory cannot keep up with a fast system clock. A two-bit ratio input sets how many idle cycles the controller leaves between successive word reads, so the memory sees at most one read every (1 + ratio) cycles. With a ratio of zero the reads run back to back.

When the processor fetches the last word of a resident line and the following line is absent, the controller reads that following line in the background. The line just used stays in its way. A loop that fits in the two ways runs with no memory traffic. A flush input drops every line.

Top module: `pfc_icache`

## Requirements
- R1: After reset no line is valid: with no fetch pending, `cpu_ready` is 1 and `mem_req` is 0, and the first fetch misses.
- R2: A miss reads the four words of the aligned line that holds the requested address (word address with its two low bits cleared), in ascending order from offset 0, whichever word was requested.
- R3: On a miss `cpu_ready` stays 0 from the request until the line is complete. The requested word is returned in the cycle after the last memory word is accepted. With a memory that accepts in its request cycle, the stall is 5 + 3×ratio cycles.
- R4: After each accepted word except the last, `mem_req` stays low for exactly `wait_cfg` cycles (0 to 3) before the next word is requested.
- R5: A fetch that hits returns the word of the memory image with `cpu_ready` high in the same cycle and causes no memory read, unless it is the prefetch case of R8.
- R6: Two lines that map to the same set are held at once, one in each way. Alternating fetches between them cause no memory reads.
- R7: A miss replaces the least recently used way of its set. Both hits and fills count as use.
- R8: A hit on offset 3 of a line whose successor line is absent starts a background fill of the successor. If the processor then asks for the successor at once, it stalls 4 + 3×ratio cycles instead of 5 + 3×ratio. If it asks after the fill is done, there is no stall. A successor line that is already present is not read again.
- R9: A flush makes every line invalid and abandons any fill in progress. The next fetch to any address misses.
- R10: While a word request is waiting for `mem_ack`, `mem_req` stays high and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines and abandon any fill |
| wait_cfg | input | 2 | Idle cycles between memory word reads |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Word address of the fetch |
| cpu_rdata | output | WORD_W | Instruction word returned |
| cpu_ready | output | 1 | Word valid (high when no fetch is pending) |
| mem_req | output | 1 | Word read request to code memory |
| mem_addr | output | ADDR_W | Word address of the memory read |
| mem_ack | input | 1 | Memory accepts the request and drives data this cycle |
| mem_rdata | input | WORD_W | Word returned by code memory |

## Verification
The bench builds the block with an 8-bit word address and two sets. Sixteen consecutive words then cover lines in both sets, and three lines that share a set force an eviction. Every ratio from 0 to 3 is swept against a memory that adds 0, 1 or 2 cycles of latency, and each stall length is computed from the formula. A sequential sweep crosses every line boundary, so the background fill of the next line is exercised at each ratio.

// File: rtl/pfc_pkg.sv
// Package: types shared by the prefetching instruction cache.
// Assumes exactly two ways, so replacement state is one bit per set.
package pfc_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_st_t;
endpackage

// File: rtl/pfc_tag_array.sv
// Module: tag, valid and LRU state for a two-way set-associative buffer.
// Provides two lookups: the fetch line and its successor.
// Assumes fill and flush never arrive together (the fill engine drops the fill on flush).
module pfc_tag_array #(
    parameter int TAG_W    = 8,
    parameter int SET_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [SET_BITS-1:0] a_idx,
    input  logic [TAG_W-1:0]    a_tag,
    output logic [1:0]          a_hit,
    output logic                a_lru,
    input  logic [SET_BITS-1:0] b_idx,
    input  logic [TAG_W-1:0]    b_tag,
    output logic                b_hit,
    output logic                b_lru,
    input  logic                touch_en,
    input  logic [SET_BITS-1:0] touch_idx,
    input  logic                touch_way,
    input  logic                fill_en,
    input  logic [SET_BITS-1:0] fill_idx,
    input  logic                fill_way,
    input  logic [TAG_W-1:0]    fill_tag
);
    localparam int SETS = 1 << SET_BITS;

    logic [SETS-1:0] lru;
    logic [1:0]      b_hit_v;
    logic [1:0]      any_vld;

    for (genvar w = 0; w < pfc_pkg::NUM_WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld;
        logic [TAG_W-1:0] tags [SETS];

        // Per-way valid bits: cleared by reset or flush, set on line commit.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                vld <= '0;
            else if (fill_en && fill_way == 1'(w))
                vld[fill_idx] <= 1'b1;
        end

        // Per-way tag storage: written when a line is committed.
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w))
                tags[fill_idx] <= fill_tag;
        end

        assign a_hit[w]   = vld[a_idx] && (tags[a_idx] == a_tag);
        assign b_hit_v[w] = vld[b_idx] && (tags[b_idx] == b_tag);
        assign any_vld[w] = |vld;
    end

    assign b_hit = |b_hit_v;
    assign a_lru = lru[a_idx];
    assign b_lru = lru[b_idx];

    // LRU bit names the way to replace next; a commit takes priority over a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru <= '0;
        else if (fill_en)
            lru[fill_idx] <= ~fill_way;
        else if (touch_en)
            lru[touch_idx] <= ~touch_way;
    end

    // R6
    dup_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_hit));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (any_vld == 2'b00));
endmodule

// File: rtl/pfc_line_store.sv
// Module: line data storage, one 64-bit line per set and way.
// Writes a full line at commit and reads one word combinationally.
// Assumes reads of invalid lines are never used.
module pfc_line_store #(
    parameter int SET_BITS  = 2,
    parameter int WORD_W    = 16,
    parameter int OFF_W     = 2,
    parameter int LINE_BITS = 64
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic                 wr_way,
    input  logic [SET_BITS-1:0]  wr_idx,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic [SET_BITS-1:0]  rd_idx,
    input  logic                 rd_way,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [WORD_W-1:0]    rd_word
);
    localparam int SETS = 1 << SET_BITS;

    logic [LINE_BITS-1:0] way_line [pfc_pkg::NUM_WAYS];
    logic [LINE_BITS-1:0] sel_line;

    for (genvar w = 0; w < pfc_pkg::NUM_WAYS; w++) begin : g_way
        logic [LINE_BITS-1:0] lines [SETS];

        // Whole-line write when the fill engine commits to this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
                lines[wr_idx] <= wr_line;
        end

        assign way_line[w] = lines[rd_idx];
    end

    assign sel_line = way_line[rd_way];
    assign rd_word  = sel_line[rd_off*WORD_W +: WORD_W];
endmodule

// File: rtl/pfc_fill_engine.sv
// Module: line fill sequencer toward the code memory.
// Reads the words of one line in ascending order and leaves wait_cfg idle
// cycles after each accepted word but the last. Stages the line and hands
// it over whole. Assumes the memory holds mem_rdata valid in the mem_ack cycle.
module pfc_fill_engine #(
    parameter int LINE_W     = 10,
    parameter int OFF_W      = 2,
    parameter int WORD_W     = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [1:0]                   wait_cfg,
    input  logic                         start_en,
    input  logic [LINE_W-1:0]            start_line,
    input  logic                         start_way,
    output logic                         busy,
    output logic                         mem_req,
    output logic [LINE_W+OFF_W-1:0]      mem_addr,
    input  logic                         mem_ack,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         done,
    output logic [LINE_W-1:0]            done_line,
    output logic                         done_way,
    output logic [WORD_W*LINE_WORDS-1:0] done_data
);
    import pfc_pkg::*;

    localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

    fill_st_t                     st;
    logic [LINE_W-1:0]            line_q;
    logic                         way_q;
    logic [OFF_W-1:0]             wcnt;
    logic [1:0]                   gap;
    logic [WORD_W*LINE_WORDS-1:0] stage;
    logic                         accept;

    assign busy      = (st == FILL_BUSY);
    assign mem_req   = busy && (gap == 2'd0);
    assign mem_addr  = {line_q, wcnt};
    assign accept    = mem_req && mem_ack;
    assign done      = accept && (wcnt == LAST) && !flush;
    assign done_line = line_q;
    assign done_way  = way_q;

    // Staged line with the final word taken straight from memory.
    always_comb begin
        done_data = stage;
        done_data[LAST*WORD_W +: WORD_W] = mem_rdata;
    end

    // Sequencer: start, pace word reads, stage data, finish or abandon.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= FILL_IDLE;
            wcnt <= '0;
            gap  <= 2'd0;
        end else if (flush) begin
            st <= FILL_IDLE;
        end else if (st == FILL_IDLE) begin
            if (start_en) begin
                st     <= FILL_BUSY;
                line_q <= start_line;
                way_q  <= start_way;
                wcnt   <= '0;
                gap    <= 2'd0;
            end
        end else if (gap != 2'd0) begin
            gap <= gap - 2'd1;
        end else if (mem_ack) begin
            stage[wcnt*WORD_W +: WORD_W] <= mem_rdata;
            if (wcnt == LAST) begin
                st <= FILL_IDLE;
            end else begin
                wcnt <= wcnt + OFF_W'(1);
                gap  <= wait_cfg;
            end
        end
    end

    // R4
    word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (wcnt != LAST) && (wait_cfg != 2'd0) && !flush |=> !mem_req);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !flush |=> mem_req && $stable(mem_addr));

    // R3
    fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req);
endmodule

// File: rtl/pfc_icache.sv
// Module: prefetching two-way instruction cache controller (top).
// Serves hits in the fetch cycle, stalls misses for a whole-line fill, and
// starts a background fill of the next line on a hit to a line's last word.
// Assumes the processor holds cpu_req and cpu_addr stable until cpu_ready.
module pfc_icache #(
    parameter int ADDR_W     = 12,
    parameter int SET_BITS   = 2,
    parameter int WORD_W     = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        wait_cfg,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int OFF_W     = $clog2(LINE_WORDS);
    localparam int LINE_W    = ADDR_W - OFF_W;
    localparam int TAG_W     = LINE_W - SET_BITS;
    localparam int LINE_BITS = WORD_W * LINE_WORDS;
    localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

    logic [LINE_W-1:0]    cpu_line, nxt_line, start_line, done_line;
    logic [OFF_W-1:0]     cpu_off;
    logic [1:0]           a_hit;
    logic                 hit, a_lru, b_hit, b_lru;
    logic                 busy, done, done_way;
    logic                 miss_start, pref_start, start_en, start_way;
    logic [LINE_BITS-1:0] done_data;

    assign cpu_line = cpu_addr[ADDR_W-1:OFF_W];
    assign cpu_off  = cpu_addr[OFF_W-1:0];
    assign nxt_line = cpu_line + LINE_W'(1);
    assign hit      = |a_hit;

    // Fill start: a demand miss wins; otherwise a next-line prefetch.
    assign miss_start = cpu_req && !hit && !busy && !flush;
    assign pref_start = cpu_req && hit && (cpu_off == LAST) && !b_hit && !busy && !flush;
    assign start_en   = miss_start || pref_start;
    assign start_line = miss_start ? cpu_line : nxt_line;
    assign start_way  = miss_start ? a_lru : b_lru;

    assign cpu_ready = !cpu_req || hit;

    pfc_tag_array #(
        .TAG_W    (TAG_W),
        .SET_BITS (SET_BITS)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .a_idx     (cpu_line[SET_BITS-1:0]),
        .a_tag     (cpu_line[LINE_W-1:SET_BITS]),
        .a_hit     (a_hit),
        .a_lru     (a_lru),
        .b_idx     (nxt_line[SET_BITS-1:0]),
        .b_tag     (nxt_line[LINE_W-1:SET_BITS]),
        .b_hit     (b_hit),
        .b_lru     (b_lru),
        .touch_en  (cpu_req && hit),
        .touch_idx (cpu_line[SET_BITS-1:0]),
        .touch_way (a_hit[1]),
        .fill_en   (done),
        .fill_idx  (done_line[SET_BITS-1:0]),
        .fill_way  (done_way),
        .fill_tag  (done_line[LINE_W-1:SET_BITS])
    );

    pfc_line_store #(
        .SET_BITS  (SET_BITS),
        .WORD_W    (WORD_W),
        .OFF_W     (OFF_W),
        .LINE_BITS (LINE_BITS)
    ) u_data (
        .clk     (clk),
        .wr_en   (done),
        .wr_way  (done_way),
        .wr_idx  (done_line[SET_BITS-1:0]),
        .wr_line (done_data),
        .rd_idx  (cpu_line[SET_BITS-1:0]),
        .rd_way  (a_hit[1]),
        .rd_off  (cpu_off),
        .rd_word (cpu_rdata)
    );

    pfc_fill_engine #(
        .LINE_W     (LINE_W),
        .OFF_W      (OFF_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .wait_cfg   (wait_cfg),
        .start_en   (start_en),
        .start_line (start_line),
        .start_way  (start_way),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .done_line  (done_line),
        .done_way   (done_way),
        .done_data  (done_data)
    );

    // R3
    miss_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_ready && !busy && !flush |=> busy);

    // R5
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ready && !busy && (cpu_off != LAST) |=> !mem_req);
endmodule

// File: tb/sim_pfc_icache.sv
// Bench: sweeps wait ratios and memory latencies on a two-set build and
// checks data, stall lengths and memory traffic against arithmetic models.
module sim_pfc_icache;
    localparam int AW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [1:0]    wait_cfg = 2'd0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [WW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [WW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int mem_lat = 0;
    int lat_cnt = 0;
    int nacks = 0;
    int stab_err = 0;
    logic          pend_q = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    logic [AW-1:0] ack_log [1024];

    always #10 clk = ~clk;

    pfc_icache #(.ADDR_W(AW), .SET_BITS(1), .WORD_W(WW), .LINE_WORDS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wait_cfg(wait_cfg),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [WW-1:0] img(input logic [AW-1:0] a);
        return WW'((int'(a) * 37 + 23040) & 16'hFFFF);
    endfunction

    assign mem_ack   = mem_req && (lat_cnt == mem_lat);
    assign mem_rdata = img(mem_addr);

    // Memory latency model, accepted-word log and request-hold monitor.
    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_ack) lat_cnt <= 0;
        else lat_cnt <= lat_cnt + 1;
        if (mem_req && mem_ack) begin
            ack_log[nacks % 1024] <= mem_addr;
            nacks <= nacks + 1;
        end
        if (pend_q && (!mem_req || mem_addr != pend_addr)) stab_err <= stab_err + 1;
        pend_q    <= rst_n && mem_req && !mem_ack && !flush;
        pend_addr <= mem_addr;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge with the request dropped.
    task automatic fetch(input int a, output int st);
        st = 0;
        cpu_addr = AW'(a);
        cpu_req = 1'b1;
        #1;
        while (!cpu_ready && st < 500) begin
            @(negedge clk);
            #1;
            st++;
        end
        chk("R5 data", int'(cpu_rdata), int'(img(AW'(a))));
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int st, n0, exp_st;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 idle outputs after reset, then first fetch misses
        chk("R1 ready idle", int'(cpu_ready), 1);
        chk("R1 no mem req", int'(mem_req), 0);
        @(negedge clk);
        fetch(0, st);
        chk("R1 first miss stall", st, 5);

        // R3 R4 R8 R2: sequential sweep over four lines at every ratio
        for (int c = 0; c < 4; c++) begin
            wait_cfg = 2'(c);
            do_flush();
            n0 = nacks;
            for (int a = 0; a < 16; a++) begin
                fetch(a, st);
                exp_st = (a == 0) ? 5 + 3 * c : ((a % 4 == 0) ? 4 + 3 * c : 0);
                chk("R8 R4 sweep stall", st, exp_st);
            end
            for (int i = 0; i < 16; i++)
                chk("R2 fill order", int'(ack_log[(n0 + i) % 1024]), i);
        end

        // R2 miss on a middle word still reads the line from offset 0
        wait_cfg = 2'd1;
        do_flush();
        n0 = nacks;
        fetch(6, st);
        chk("R3 stall ratio 1", st, 8);
        for (int i = 0; i < 4; i++)
            chk("R2 aligned line", int'(ack_log[(n0 + i) % 1024]), 4 + i);

        // R6 two lines of set 0 resident together
        wait_cfg = 2'd0;
        do_flush();
        fetch(0, st);
        chk("R6 miss A", st, 5);
        fetch(8, st);
        chk("R6 miss B", st, 5);
        n0 = nacks;
        for (int i = 0; i < 5; i++) begin
            fetch(1, st);  chk("R6 hit A", st, 0);
            fetch(9, st);  chk("R6 hit B", st, 0);
            fetch(2, st);  chk("R6 hit A", st, 0);
            fetch(10, st); chk("R6 hit B", st, 0);
        end
        chk("R6 no memory reads", nacks - n0, 0);

        // R7 LRU replacement
        fetch(0, st);
        chk("R7 touch A", st, 0);
        fetch(16, st);
        chk("R7 miss C", st, 5);
        fetch(0, st);
        chk("R7 A kept", st, 0);
        fetch(8, st);
        chk("R7 B evicted", st, 5);

        // R8 background fill completes before use; present successor not refetched
        do_flush();
        fetch(20, st);
        chk("R8 miss", st, 5);
        fetch(23, st);
        chk("R5 hit last word", st, 0);
        idle(12);
        n0 = nacks;
        fetch(24, st);
        chk("R8 prefetched stall", st, 0);
        chk("R8 no extra reads", nacks - n0, 0);
        for (int i = 0; i < 4; i++)
            chk("R8 prefetch addr", int'(ack_log[(n0 - 4 + i) % 1024]), 24 + i);
        n0 = nacks;
        fetch(23, st);
        idle(12);
        chk("R8 successor present", nacks - n0, 0);

        // R9 flush drops resident lines
        fetch(24, st);
        chk("R9 before flush", st, 0);
        do_flush();
        fetch(24, st);
        chk("R9 after flush", st, 5);

        // R10 R4 ratio and latency sweep
        for (int lt = 0; lt < 3; lt++) begin
            for (int c = 0; c < 4; c++) begin
                mem_lat = lt;
                wait_cfg = 2'(c);
                do_flush();
                fetch(40, st);
                chk("R10 R4 latency stall", st, 1 + 4 * (1 + lt) + 3 * c);
            end
        end
        mem_lat = 0;
        chk("R10 request held", stab_err, 0);

        finish_run();
    end
endmodule